// File: doc/BRIEF.md
# Vector Indexed Memory Sequencer

This block carries out memory operations for one four-lane vector of 32-bit elements. A contiguous load or store goes out as a single wide access at the scalar base address. Lane i occupies bytes base+4*i to base+4*i+3. Gather loads and scatter stores compute one address per lane as the scalar base plus that lane's index element. They issue one scalar access per lane, in ascending lane order, on a separate request/response port.

Each lane has a mask bit. A cleared bit keeps that lane out of memory altogether, and a lane that is not loaded keeps its old destination value. The destination vector register sits inside the block and appears on an output. An operation is accepted only while the sequencer is idle. A single-cycle done pulse follows the completion of the last active lane.

Top module: `vsg_seq`

## Requirements
- R1: With op_kind 0 (contiguous load), the block makes exactly one wide access with wmem_addr equal to op_base and wmem_we low, and it makes no scalar access. On the wide acknowledge, every active lane i of the destination takes bits [32*i+31:32*i] of wmem_rdata.
- R2: With op_kind 1 (contiguous store), the block makes exactly one wide write at op_base. It drives the whole op_wdata vector, and wmem_lane_en equals op_mask, so only active lanes are written.
- R3: With op_kind 2 (gather), lane i reads address op_base plus index lane i, as a byte offset that wraps at 32 bits. The returned word goes to destination lane i.
- R4: With op_kind 3 (scatter), lane i writes wdata lane i to address op_base plus index lane i, with the same wraparound.
- R5: Indexed operations issue one scalar access at a time, in ascending lane order from 0 to 3, and they make no wide access.
- R6: A lane whose mask bit is 0 makes no memory access. On loads, its destination lane keeps its previous value.
- R7: done is high for exactly one cycle. That cycle is the one after the acknowledge of the last active access, and op_ready is high in the cycle that follows it.
- R8: An operation whose mask is all zero raises done in the cycle after acceptance and makes no request on either port.
- R9: op_valid is ignored while op_ready is low. No access or register update results from it.
- R10: A request on either port stays asserted, with stable address, write enable and data, until it is acknowledged.
- R11: After reset, op_ready is 1, done and both requests are 0, and the destination vector is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | New operation offered |
| op_kind | input | 2 | 0 contiguous load, 1 contiguous store, 2 gather, 3 scatter |
| op_base | input | 32 | Scalar base byte address |
| op_index | input | 128 | Per-lane byte offsets (lane i at bits 32i+31:32i) |
| op_mask | input | 4 | Per-lane enable |
| op_wdata | input | 128 | Store data vector |
| op_ready | output | 1 | Sequencer idle, operation accepted on op_valid |
| done | output | 1 | One-cycle completion pulse |
| vreg | output | 128 | Destination vector register |
| wmem_req | output | 1 | Wide access request |
| wmem_we | output | 1 | Wide access is a write |
| wmem_addr | output | 32 | Wide access base address |
| wmem_wdata | output | 128 | Wide write data |
| wmem_lane_en | output | 4 | Wide write lane enables |
| wmem_ack | input | 1 | Wide access complete |
| wmem_rdata | input | 128 | Wide read data, valid with ack |
| smem_req | output | 1 | Scalar access request |
| smem_we | output | 1 | Scalar access is a write |
| smem_addr | output | 32 | Scalar byte address |
| smem_wdata | output | 32 | Scalar write data |
| smem_ack | input | 1 | Scalar access complete |
| smem_rdata | input | 32 | Scalar read data, valid with ack |

## Verification
The assertions check three things on every cycle. Idle, busy on one port and done are mutually exclusive. Requests hold steady until they are acknowledged, and every scalar request targets an active lane, with lanes advancing strictly upward. Done always hands back to idle. Only the directed scenarios can show whether the addresses are right, whether the base-plus-index sum wraps, whether loaded data lands in the correct lane and unloaded lanes are kept, which memory words a store actually changed, and whether an offer made while busy was ignored.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    OP_VLD     = 2'd0,
    OP_VST     = 2'd1,
    OP_GATHER  = 2'd2,
    OP_SCATTER = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WIDE = 2'd1,
    S_ELEM = 2'd2,
    S_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/vsg_pick.sv
// Lowest set lane of mask at or above position 'from'.
module vsg_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  input  logic [IW:0]   from,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vsg_agen.sv
// Per-lane address generation and lane selection for the scalar port.
module vsg_agen #(
  parameter int N  = 4,
  parameter int EW = 32,
  parameter int AW = 32,
  parameter int IW = 2
) (
  input  logic [AW-1:0]   base,
  input  logic [N*EW-1:0] index,
  input  logic [N*EW-1:0] wvec,
  input  logic [IW-1:0]   sel,
  output logic [AW-1:0]   addr,
  output logic [EW-1:0]   wlane
);
  logic [AW-1:0] lane_addr [N];
  logic [EW-1:0] lane_data [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane_addr[g] = base + AW'(index[g*EW +: EW]);
    assign lane_data[g] = wvec[g*EW +: EW];
  end

  assign addr  = lane_addr[sel];
  assign wlane = lane_data[sel];
endmodule

// File: rtl/vsg_dreg.sv
// Destination vector register with per-lane write enables.
module vsg_dreg #(
  parameter int N  = 4,
  parameter int EW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    lane_we,
  input  logic            narrow_sel,
  input  logic [N*EW-1:0] wide_in,
  input  logic [EW-1:0]   narrow_in,
  output logic [N*EW-1:0] vreg
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [EW-1:0] lane_q, lane_d;
    assign lane_d = narrow_sel ? narrow_in : wide_in[g*EW +: EW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[g]) lane_q <= lane_d;
    end
    assign vreg[g*EW +: EW] = lane_q;
  end
endmodule

// File: rtl/vsg_seq.sv
module vsg_seq
  import vsg_pkg::*;
#(
  parameter int NUM_EL = 4,
  parameter int EW     = 32,
  parameter int AW     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [1:0]           op_kind,
  input  logic [AW-1:0]        op_base,
  input  logic [NUM_EL*EW-1:0] op_index,
  input  logic [NUM_EL-1:0]    op_mask,
  input  logic [NUM_EL*EW-1:0] op_wdata,
  output logic                 op_ready,
  output logic                 done,
  output logic [NUM_EL*EW-1:0] vreg,
  output logic                 wmem_req,
  output logic                 wmem_we,
  output logic [AW-1:0]        wmem_addr,
  output logic [NUM_EL*EW-1:0] wmem_wdata,
  output logic [NUM_EL-1:0]    wmem_lane_en,
  input  logic                 wmem_ack,
  input  logic [NUM_EL*EW-1:0] wmem_rdata,
  output logic                 smem_req,
  output logic                 smem_we,
  output logic [AW-1:0]        smem_addr,
  output logic [EW-1:0]        smem_wdata,
  input  logic                 smem_ack,
  input  logic [EW-1:0]        smem_rdata
);
  localparam int IW = (NUM_EL > 1) ? $clog2(NUM_EL) : 1;
  localparam int VW = NUM_EL * EW;

  seq_st_e             st_q, st_d;
  vop_e                kind_q;
  logic [AW-1:0]       base_q;
  logic [VW-1:0]       index_q, wdata_q;
  logic [NUM_EL-1:0]   mask_q;
  logic [IW-1:0]       ptr_q, ptr_d;
  logic                capture;
  logic                pick_hit;
  logic [IW-1:0]       pick_idx;
  logic [IW:0]         pick_from;
  logic [NUM_EL-1:0]   pick_mask;
  logic [NUM_EL-1:0]   lane_we;
  logic                is_contig;

  assign is_contig = (op_kind == OP_VLD) || (op_kind == OP_VST);
  assign pick_mask = (st_q == S_IDLE) ? op_mask : mask_q;
  assign pick_from = (st_q == S_IDLE) ? '0 : ({1'b0, ptr_q} + 1'b1);

  vsg_pick #(.N(NUM_EL), .IW(IW)) u_pick (
    .mask (pick_mask),
    .from (pick_from),
    .hit  (pick_hit),
    .idx  (pick_idx)
  );

  vsg_agen #(.N(NUM_EL), .EW(EW), .AW(AW), .IW(IW)) u_agen (
    .base  (base_q),
    .index (index_q),
    .wvec  (wdata_q),
    .sel   (ptr_q),
    .addr  (smem_addr),
    .wlane (smem_wdata)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    capture = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (op_valid) begin
          capture = 1'b1;
          ptr_d   = pick_idx;
          if (!pick_hit)      st_d = S_DONE;
          else if (is_contig) st_d = S_WIDE;
          else                st_d = S_ELEM;
        end
      end
      S_WIDE: if (wmem_ack) st_d = S_DONE;
      S_ELEM: begin
        if (smem_ack) begin
          if (pick_hit) ptr_d = pick_idx;
          else          st_d  = S_DONE;
        end
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ptr_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
    end
  end

  // Operation registers, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= OP_VLD;
      base_q  <= '0;
      index_q <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (capture) begin
      kind_q  <= vop_e'(op_kind);
      base_q  <= op_base;
      index_q <= op_index;
      wdata_q <= op_wdata;
      mask_q  <= op_mask;
    end
  end

  always_comb begin
    lane_we = '0;
    if (st_q == S_WIDE && wmem_ack && kind_q == OP_VLD)
      lane_we = mask_q;
    else if (st_q == S_ELEM && smem_ack && kind_q == OP_GATHER)
      lane_we = NUM_EL'(1) << ptr_q;
  end

  vsg_dreg #(.N(NUM_EL), .EW(EW)) u_dreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_we    (lane_we),
    .narrow_sel (st_q == S_ELEM),
    .wide_in    (wmem_rdata),
    .narrow_in  (smem_rdata),
    .vreg       (vreg)
  );

  assign op_ready     = (st_q == S_IDLE);
  assign done         = (st_q == S_DONE);
  assign wmem_req     = (st_q == S_WIDE);
  assign wmem_we      = (kind_q == OP_VST);
  assign wmem_addr    = base_q;
  assign wmem_wdata   = wdata_q;
  assign wmem_lane_en = mask_q;
  assign smem_req     = (st_q == S_ELEM);
  assign smem_we      = (kind_q == OP_SCATTER);
endmodule

// File: rtl/vsg_seq_chk.sv
module vsg_seq_chk #(
  parameter int NUM_EL = 4,
  parameter int AW     = 32,
  parameter int EW     = 32,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              done,
  input logic              wmem_req,
  input logic              wmem_ack,
  input logic              wmem_we,
  input logic [AW-1:0]     wmem_addr,
  input logic              smem_req,
  input logic              smem_ack,
  input logic              smem_we,
  input logic [AW-1:0]     smem_addr,
  input logic [EW-1:0]     smem_wdata,
  input logic [IW-1:0]     ptr_q,
  input logic [NUM_EL-1:0] mask_q
);
  // R5, R7: idle, done and each port activity exclude one another
  a_r5_single_activity: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_ready, done, wmem_req, smem_req}));

  a_r10_smem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    smem_req && !smem_ack |=> smem_req && $stable(smem_addr) && $stable(smem_we)
                              && $stable(smem_wdata));

  a_r10_wmem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wmem_req && !wmem_ack |=> wmem_req && $stable(wmem_addr) && $stable(wmem_we));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && op_ready);

  a_r6_active_lane: assert property (@(posedge clk) disable iff (!rst_n)
    smem_req |-> mask_q[ptr_q]);

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    smem_req && smem_ack |=> !smem_req || (ptr_q > $past(ptr_q)));
endmodule

bind vsg_seq vsg_seq_chk #(.NUM_EL(NUM_EL), .AW(AW), .EW(EW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_ready   (op_ready),
  .done       (done),
  .wmem_req   (wmem_req),
  .wmem_ack   (wmem_ack),
  .wmem_we    (wmem_we),
  .wmem_addr  (wmem_addr),
  .smem_req   (smem_req),
  .smem_ack   (smem_ack),
  .smem_we    (smem_we),
  .smem_addr  (smem_addr),
  .smem_wdata (smem_wdata),
  .ptr_q      (ptr_q),
  .mask_q     (mask_q)
);

// File: tb/sim_vsg_seq.sv
module sim_vsg_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [1:0]   op_kind = 2'd0;
  logic [31:0]  op_base = '0;
  logic [127:0] op_index = '0;
  logic [3:0]   op_mask = '0;
  logic [127:0] op_wdata = '0;
  logic         op_ready, done;
  logic [127:0] vreg;
  logic         wmem_req, wmem_we, wmem_ack;
  logic [31:0]  wmem_addr;
  logic [127:0] wmem_wdata, wmem_rdata;
  logic [3:0]   wmem_lane_en;
  logic         smem_req, smem_we, smem_ack;
  logic [31:0]  smem_addr, smem_wdata, smem_rdata;

  int tests = 0, fails = 0;
  int lat = 0;
  int s_cnt = 0, w_cnt = 0;
  logic [31:0] mem [64];
  logic [31:0] slog [64];
  int slog_n = 0;

  always #2 clk = ~clk;

  vsg_seq u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_base(op_base), .op_index(op_index), .op_mask(op_mask), .op_wdata(op_wdata),
    .op_ready(op_ready), .done(done), .vreg(vreg),
    .wmem_req(wmem_req), .wmem_we(wmem_we), .wmem_addr(wmem_addr),
    .wmem_wdata(wmem_wdata), .wmem_lane_en(wmem_lane_en), .wmem_ack(wmem_ack),
    .wmem_rdata(wmem_rdata), .smem_req(smem_req), .smem_we(smem_we),
    .smem_addr(smem_addr), .smem_wdata(smem_wdata), .smem_ack(smem_ack),
    .smem_rdata(smem_rdata)
  );

  // Memory model: 64 words, word index from address bits 7:2
  assign smem_ack   = smem_req && (s_cnt == lat);
  assign wmem_ack   = wmem_req && (w_cnt == lat);
  assign smem_rdata = mem[smem_addr[7:2]];
  always_comb
    for (int i = 0; i < 4; i++) wmem_rdata[i*32 +: 32] = mem[wmem_addr[7:2] + 6'(i)];

  always @(posedge clk) begin
    s_cnt <= (smem_req && !smem_ack) ? s_cnt + 1 : 0;
    w_cnt <= (wmem_req && !wmem_ack) ? w_cnt + 1 : 0;
    if (smem_req && smem_ack) begin
      if (smem_we) mem[smem_addr[7:2]] <= smem_wdata;
      slog[slog_n[5:0]] <= smem_addr;
      slog_n <= slog_n + 1;
    end
    if (wmem_req && wmem_ack && wmem_we)
      for (int i = 0; i < 4; i++)
        if (wmem_lane_en[i]) mem[wmem_addr[7:2] + 6'(i)] <= wmem_wdata[i*32 +: 32];
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pack4(input logic [31:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  // Run one operation; ncyc = negedges from acceptance until done is seen
  task automatic run_op(input logic [1:0] k, input logic [31:0] b, input logic [127:0] ix,
                        input logic [3:0] m, input logic [127:0] wd,
                        output int ncyc, output int nw, output int ns);
    logic        pend;
    logic [31:0] paddr;
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_base = b; op_index = ix; op_mask = m; op_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0;
    ncyc = 1; nw = 0; ns = 0; pend = 1'b0; paddr = '0;
    while (!done && ncyc < 300) begin
      if (wmem_req) nw++;
      if (pend) chk("R10 held request", {96'd0, smem_req, smem_addr[30:0]}, {96'd0, 1'b1, paddr[30:0]});
      if (smem_req && smem_ack) ns++;
      pend  = smem_req && !smem_ack;
      paddr = smem_addr;
      @(negedge clk);
      ncyc++;
    end
    if (ncyc >= 300) chk("R7 completion timeout", 1, 0);
    @(negedge clk);
    chk("R7 done one cycle then ready", {126'd0, done, op_ready}, 128'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset ready/done/req", {124'd0, op_ready, done, wmem_req, smem_req}, 128'h8);
    chk("R11 reset vreg", vreg, '0);
  endtask

  task automatic t_vload();
    int n, nw, ns, s0;
    s0 = slog_n; lat = 1;
    run_op(2'd0, 32'h40, '0, 4'b1111, '0, n, nw, ns);
    chk("R1 full load data", vreg, pack4(32'hA000_0010, 32'hA000_0011, 32'hA000_0012, 32'hA000_0013));
    chk("R1 one wide access, latency", {n, nw}, {32'd3, 32'd2});
    chk("R1 no scalar access", slog_n - s0, 0);
    lat = 0;
    run_op(2'd0, 32'h80, '0, 4'b0101, '0, n, nw, ns);
    chk("R6 masked contiguous load keeps lanes",
        vreg, pack4(32'hA000_0020, 32'hA000_0011, 32'hA000_0022, 32'hA000_0013));
  endtask

  task automatic t_vstore();
    int n, nw, ns;
    lat = 2;
    run_op(2'd1, 32'hC0, '0, 4'b1011, pack4(32'hB0, 32'hB1, 32'hB2, 32'hB3), n, nw, ns);
    chk("R2 store lanes written", pack4(mem[48], mem[49], mem[50], mem[51]),
        pack4(32'hB0, 32'hB1, 32'hA000_0032, 32'hB3));
    chk("R2 cycles", n, 4);
  endtask

  task automatic t_gather();
    int n, nw, ns, s0;
    s0 = slog_n; lat = 1;
    run_op(2'd2, 32'h1000_0000, pack4(32'h28, 32'h4, 32'h3C, 32'h10), 4'b1111, '0, n, nw, ns);
    chk("R3 gather data", vreg, pack4(32'hA000_000A, 32'hA000_0001, 32'hA000_000F, 32'hA000_0004));
    chk("R5 ascending addresses", pack4(slog[s0[5:0]], slog[6'(s0 + 1)], slog[6'(s0 + 2)], slog[6'(s0 + 3)]),
        pack4(32'h1000_0028, 32'h1000_0004, 32'h1000_003C, 32'h1000_0010));
    chk("R5 serial cycles, no wide", {n, nw, ns}, {32'd9, 32'd0, 32'd4});
    s0 = slog_n; lat = 0;
    run_op(2'd2, 32'hFFFF_FFF0, pack4(32'h14, 32'h0, 32'h18, 32'h30), 4'b1010, '0, n, nw, ns);
    chk("R3 wrap and R6 masked gather", vreg,
        pack4(32'hA000_000A, 32'hA000_003C, 32'hA000_000F, 32'hA000_0008));
    chk("R6 only active addresses", {slog_n - s0, slog[s0[5:0]], slog[6'(s0 + 1)]},
        {32'd2, 32'hFFFF_FFF0, 32'h0000_0020});
    chk("R6 gather cycles", n, 3);
  endtask

  task automatic t_scatter();
    int n, nw, ns, s0;
    s0 = slog_n; lat = 1;
    run_op(2'd3, 32'h0, pack4(32'hF0, 32'h4, 32'h8, 32'hC), 4'b1101,
           pack4(32'hC0, 32'hC1, 32'hC2, 32'hC3), n, nw, ns);
    chk("R4 scatter memory", pack4(mem[60], mem[1], mem[2], mem[3]),
        pack4(32'hC0, 32'hA000_0001, 32'hC2, 32'hC3));
    chk("R5 R6 scatter order", pack4(slog[s0[5:0]], slog[6'(s0 + 1)], slog[6'(s0 + 2)], 32'(slog_n - s0)),
        pack4(32'hF0, 32'h8, 32'hC, 32'd3));
    chk("R4 cycles", {n, nw}, {32'd7, 32'd0});
  endtask

  task automatic t_zero_mask();
    int n, nw, ns, s0;
    logic [127:0] v0;
    v0 = vreg; s0 = slog_n; lat = 0;
    run_op(2'd2, 32'h0, '0, 4'b0000, '0, n, nw, ns);
    chk("R8 gather zero mask", {n, nw, slog_n - s0}, {32'd1, 32'd0, 32'd0});
    chk("R8 vreg unchanged", vreg, v0);
    run_op(2'd1, 32'h0, '0, 4'b0000, {4{32'hDEAD}}, n, nw, ns);
    chk("R8 store zero mask", {n, nw, mem[0]}, {32'd1, 32'd0, 32'hA000_0000});
  endtask

  task automatic t_busy();
    int n, nw, s0;
    s0 = slog_n; lat = 3; nw = 0;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd2; op_base = 32'h0; op_mask = 4'b1111;
    op_index = pack4(32'h10, 32'h14, 32'h18, 32'h1C);
    @(negedge clk);
    op_kind = 2'd1; op_base = 32'h80; op_wdata = {4{32'h5555}};
    n = 1;
    while (!done && n < 300) begin
      if (wmem_req) nw++;
      @(negedge clk);
      n++;
    end
    op_valid = 1'b0;
    chk("R9 busy offer ignored", {n, nw, slog_n - s0}, {32'd17, 32'd0, 32'd4});
    chk("R9 no store landed", mem[32], 32'hA000_0020);
    chk("R9 gather data intact", vreg, pack4(32'hA000_0004, 32'hA000_0005, 32'hA000_0006, 32'hA000_0007));
    @(negedge clk);
    chk("R9 back to idle", {127'd0, op_ready}, 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] <= 32'hA000_0000 + 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_vload();
    t_vstore();
    t_gather();
    t_scatter();
    t_zero_mask();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule